// File: doc/BRIEF.md
# Autolock Threshold Sequencer

This block decides when a laser lock loop may close during a spectrum sweep. Each accepted input sample is added to a running sum of the most recent `time_scale` samples. That windowed sum is tested against a short programmed list of signed thresholds, one instruction at a time. An instruction matches when the sum passes its threshold on the side the threshold's sign selects. Each instruction also carries a minimum number of samples that must pass, counted from the previous advance, before it may match.

Once every active instruction has matched, the block waits a programmed number of further samples. After that wait, if the controller is requesting a lock, it raises a sticky lock enable. A pulse on `at_start` at the start of a sweep rewinds the sequence and forgets the sample history. Samples count only while the sweep runs upward and the data-valid enable is high.

Top module: `autolock_seq`

## Requirements
- R1: After `at_start`, the windowed sum is the sum of the most recent `time_scale` accepted samples (fewer if fewer have arrived). `time_scale` must lie in 1..MAX_WIN. A constant 1000 with `time_scale` 5 rises to 5000 and stays at 5000.
- R2: An instruction whose threshold is zero or positive matches only on a sample whose new windowed sum is strictly greater than the threshold.
- R3: An instruction whose threshold is negative matches only on a sample whose new windowed sum is strictly less than the threshold. A sum of the opposite sign never satisfies a threshold.
- R4: On a match, `instr_idx` increments by exactly one on the clock edge that takes that sample.
- R5: Instruction k may match only on a sample preceded by at least wait k accepted samples since the last advance (or since `at_start`). The count restarts from zero at every advance.
- R6: `n_instr` selects how many instructions are active (0..N_MAX). A larger value acts as N_MAX. Instruction k takes threshold bits `thr_flat[k*THR_W +: THR_W]` and wait bits `wait_flat[k*WAIT_W +: WAIT_W]`.
- R7: Once `instr_idx` has reached the active count, `turn_on_lock` rises on the edge of the (final_wait+1)-th accepted sample that follows, provided `request_lock` is high.
- R8: `turn_on_lock` is set only on a sample taken while `request_lock` is high. Once set, it stays high, regardless of `request_lock`, until `at_start`.
- R9: `at_start` takes priority over a sample. On the next edge it clears `instr_idx`, `turn_on_lock`, the wait count and the sample history.
- R10: A sample is accepted only when `sample_valid` and `sweep_up` are both high. Otherwise no state changes.
- R11: Thresholds are sign-extended to the full width of the windowed sum before comparison. With a sum above the 16-bit range, a threshold of -30000 does not match.
- R12: Both outputs are registered and reset (synchronous, active high) to `instr_idx` = 0 and `turn_on_lock` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | DATA_W | Signed input sample |
| sample_valid | input | 1 | Sample present this cycle |
| sweep_up | input | 1 | Sweep is running upward; samples count only then |
| at_start | input | 1 | Rewind sequence and clear history |
| request_lock | input | 1 | Lock is wanted; gates raising of the lock enable |
| time_scale | input | $clog2(MAX_WIN+1) | Window length in samples, 1..MAX_WIN |
| n_instr | input | $clog2(N_MAX+1) | Number of active instructions |
| thr_flat | input | N_MAX*THR_W | Signed thresholds, instruction k at slice k |
| wait_flat | input | N_MAX*WAIT_W | Minimum waits, instruction k at slice k |
| final_wait | input | WAIT_W | Samples to wait after the last match |
| instr_idx | output | $clog2(N_MAX+1) | Index of the instruction being sought |
| turn_on_lock | output | 1 | Lock enable |

## Verification
The hardest situations to reach are those where a threshold is already satisfied while its wait has not yet run out. The stimulus reaches them with a window of one sample, so each input value is the sum directly. It then holds a matching value for exactly one sample fewer than the wait and checks that the index has not moved. Sign extension needs a sum beyond the threshold width. It is reached with the largest window and near-full-scale samples against a negative threshold. Stale history after `at_start` is exposed by refilling the window with large values, rewinding, and sending one small sample that would match only if the old values survived.

// File: rtl/als_pkg.sv
package als_pkg;
  // which side of the threshold counts as a match
  typedef enum logic {
    POL_ABOVE = 1'b0,
    POL_BELOW = 1'b1
  } pol_e;
endpackage

// File: rtl/als_window_sum.sv
// Running sum of the last `span` accepted samples. The history lives in a
// power-of-two circular buffer with no reset; validity is tracked by a fill
// count so a clear needs no memory sweep.
module als_window_sum #(
  parameter int DATA_W  = 14,
  parameter int MAX_WIN = 16,
  parameter int SUM_W   = DATA_W + $clog2(MAX_WIN) + 1,
  parameter int TS_W    = $clog2(MAX_WIN + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    take,
  input  logic signed [DATA_W-1:0] sample,
  input  logic [TS_W-1:0]         span,
  output logic signed [SUM_W-1:0] sum_q,
  output logic signed [SUM_W-1:0] sum_nxt
);
  localparam int AW = $clog2(MAX_WIN);

  logic signed [DATA_W-1:0] hist [MAX_WIN];
  logic [AW-1:0]            wr_ptr;
  logic [AW-1:0]            rd_ptr;
  logic [TS_W-1:0]          fill;
  logic signed [DATA_W-1:0] oldest;

  assign rd_ptr  = wr_ptr - span[AW-1:0];
  assign oldest  = (fill >= span) ? hist[rd_ptr] : '0;
  assign sum_nxt = sum_q + SUM_W'(sample) - SUM_W'(oldest);

  always_ff @(posedge clk) begin
    if (take) hist[wr_ptr] <= sample;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      fill   <= '0;
      sum_q  <= '0;
    end else if (take) begin
      wr_ptr <= wr_ptr + 1'b1;
      if (fill != TS_W'(MAX_WIN)) fill <= fill + 1'b1;
      sum_q  <= sum_nxt;
    end
  end

  a_r10_sum_hold: assert property (@(posedge clk) disable iff (rst)
    (!take && !clear) |=> $stable(sum_q));
  a_r9_sum_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (sum_q == '0));
  a_r1_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill <= TS_W'(MAX_WIN));
endmodule

// File: rtl/als_thr_cmp.sv
// Sign-aware threshold test in the full sum width.
module als_thr_cmp #(
  parameter int SUM_W = 19,
  parameter int THR_W = 16
) (
  input  logic signed [SUM_W-1:0] sum,
  input  logic signed [THR_W-1:0] thr,
  output logic                    hit
);
  import als_pkg::*;

  pol_e                    pol;
  logic signed [SUM_W-1:0] thr_ext;

  assign thr_ext = SUM_W'(thr);
  assign pol     = thr[THR_W-1] ? POL_BELOW : POL_ABOVE;

  always_comb begin
    case (pol)
      POL_ABOVE: hit = (sum > thr_ext);
      default:   hit = (sum < thr_ext);
    endcase
  end
endmodule

// File: rtl/als_step_ctrl.sv
// Instruction index, wait counting and the sticky lock enable.
module als_step_ctrl #(
  parameter int N_MAX  = 4,
  parameter int WAIT_W = 12,
  parameter int IDX_W  = $clog2(N_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic              hit,
  input  logic [WAIT_W-1:0] wait_cur,
  input  logic [WAIT_W-1:0] final_wait,
  input  logic [IDX_W-1:0]  n_instr,
  input  logic              request_lock,
  output logic [IDX_W-1:0]  idx_q,
  output logic              lock_q
);
  logic [IDX_W-1:0]  n_eff;
  logic              done;
  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] cnt_inc;

  assign n_eff   = (n_instr > IDX_W'(N_MAX)) ? IDX_W'(N_MAX) : n_instr;
  assign done    = (idx_q >= n_eff);
  assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx_q  <= '0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (take) begin
      if (!done) begin
        if (hit && (cnt_q >= wait_cur)) begin
          idx_q <= idx_q + 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_inc;
        end
      end else begin
        cnt_q <= cnt_inc;
        if (request_lock && (cnt_q >= final_wait)) lock_q <= 1'b1;
      end
    end
  end

  a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (idx_q == $past(idx_q) || idx_q == $past(idx_q) + 1'b1));
  a_r9_rewind: assert property (@(posedge clk) disable iff (rst)
    clear |=> (idx_q == '0 && !lock_q));
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !clear) |=> lock_q);
  a_r8_needs_request: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(request_lock));
  a_r7_after_last: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(done));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!take && !clear) |=> ($stable(idx_q) && $stable(lock_q)));
  a_r6_idx_bound: assert property (@(posedge clk) disable iff (rst)
    idx_q <= IDX_W'(N_MAX));
endmodule

// File: rtl/autolock_seq.sv
module autolock_seq #(
  parameter int DATA_W  = 14,
  parameter int THR_W   = 16,
  parameter int MAX_WIN = 16,
  parameter int N_MAX   = 4,
  parameter int WAIT_W  = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic signed [DATA_W-1:0]      sample_in,
  input  logic                          sample_valid,
  input  logic                          sweep_up,
  input  logic                          at_start,
  input  logic                          request_lock,
  input  logic [$clog2(MAX_WIN+1)-1:0]  time_scale,
  input  logic [$clog2(N_MAX+1)-1:0]    n_instr,
  input  logic [N_MAX*THR_W-1:0]        thr_flat,
  input  logic [N_MAX*WAIT_W-1:0]       wait_flat,
  input  logic [WAIT_W-1:0]             final_wait,
  output logic [$clog2(N_MAX+1)-1:0]    instr_idx,
  output logic                          turn_on_lock
);
  localparam int TS_W  = $clog2(MAX_WIN + 1);
  localparam int IDX_W = $clog2(N_MAX + 1);
  localparam int SUM_W = DATA_W + $clog2(MAX_WIN) + 1;

  logic                    take;
  logic signed [SUM_W-1:0] sum_q;
  logic signed [SUM_W-1:0] sum_nxt;
  logic signed [THR_W-1:0] thr_arr  [N_MAX];
  logic [WAIT_W-1:0]       wait_arr [N_MAX];
  logic signed [THR_W-1:0] thr_cur;
  logic [WAIT_W-1:0]       wait_cur;
  logic                    hit;

  assign take = sample_valid && sweep_up;

  for (genvar k = 0; k < N_MAX; k++) begin : g_unpack
    assign thr_arr[k]  = thr_flat[k*THR_W +: THR_W];
    assign wait_arr[k] = wait_flat[k*WAIT_W +: WAIT_W];
  end

  always_comb begin
    thr_cur  = '0;
    wait_cur = '0;
    for (int k = 0; k < N_MAX; k++) begin
      if (instr_idx == IDX_W'(k)) begin
        thr_cur  = thr_arr[k];
        wait_cur = wait_arr[k];
      end
    end
  end

  als_window_sum #(
    .DATA_W (DATA_W),
    .MAX_WIN(MAX_WIN),
    .SUM_W  (SUM_W),
    .TS_W   (TS_W)
  ) u_win (
    .clk    (clk),
    .rst    (rst),
    .clear  (at_start),
    .take   (take),
    .sample (sample_in),
    .span   (time_scale),
    .sum_q  (sum_q),
    .sum_nxt(sum_nxt)
  );

  als_thr_cmp #(
    .SUM_W(SUM_W),
    .THR_W(THR_W)
  ) u_cmp (
    .sum(sum_nxt),
    .thr(thr_cur),
    .hit(hit)
  );

  als_step_ctrl #(
    .N_MAX (N_MAX),
    .WAIT_W(WAIT_W),
    .IDX_W (IDX_W)
  ) u_step (
    .clk         (clk),
    .rst         (rst),
    .clear       (at_start),
    .take        (take),
    .hit         (hit),
    .wait_cur    (wait_cur),
    .final_wait  (final_wait),
    .n_instr     (n_instr),
    .request_lock(request_lock),
    .idx_q       (instr_idx),
    .lock_q      (turn_on_lock)
  );

  // a match never pairs a sum with a threshold of the opposite sign
  a_r3_sign_agree: assert property (@(posedge clk) disable iff (rst)
    hit |-> (sum_nxt[SUM_W-1] == thr_cur[THR_W-1]));
  a_r1_sum_registered: assert property (@(posedge clk) disable iff (rst)
    (take && !at_start) |=> (sum_q == $past(sum_nxt)));
endmodule

// File: tb/autolock_seq_tb.sv
module autolock_seq_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic signed [15:0] v;
    logic [4:0]         ts;
    logic [4:0]         n;
    logic signed [15:0] thr;
    logic [11:0]        wt;
    logic               exp_idx;
  } row_t;

  // value, window, sample count, threshold, wait, expected index
  localparam row_t ROWS [12] = '{
    '{16'sd1000,  5'd5,  5'd5,  16'sd4500,   12'd0, 1'b1},
    '{16'sd1000,  5'd5,  5'd5,  16'sd5000,   12'd0, 1'b0},
    '{-16'sd1000, 5'd5,  5'd5,  16'sd4500,   12'd0, 1'b0},
    '{-16'sd1000, 5'd5,  5'd5,  -16'sd4500,  12'd0, 1'b1},
    '{-16'sd1000, 5'd5,  5'd5,  -16'sd5000,  12'd0, 1'b0},
    '{16'sd1000,  5'd5,  5'd5,  -16'sd100,   12'd0, 1'b0},
    '{16'sd1000,  5'd5,  5'd5,  16'sd500,    12'd5, 1'b0},
    '{16'sd1000,  5'd5,  5'd5,  16'sd500,    12'd4, 1'b1},
    '{16'sd1000,  5'd5,  5'd12, 16'sd5001,   12'd0, 1'b0},
    '{16'sd100,   5'd16, 5'd16, 16'sd1550,   12'd0, 1'b1},
    '{16'sd8000,  5'd16, 5'd16, -16'sd30000, 12'd0, 1'b0},
    '{16'sd8000,  5'd16, 5'd16, 16'sd30000,  12'd0, 1'b1}
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic signed [13:0] sample_in = '0;
  logic               sample_valid = 1'b0;
  logic               sweep_up = 1'b1;
  logic               at_start = 1'b0;
  logic               request_lock = 1'b0;
  logic [4:0]         time_scale = 5'd1;
  logic [2:0]         n_instr = 3'd1;
  logic [63:0]        thr_flat = '0;
  logic [47:0]        wait_flat = '0;
  logic [11:0]        final_wait = '0;
  logic [2:0]         instr_idx;
  logic               turn_on_lock;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  autolock_seq u_dut (
    .clk(clk), .rst(rst), .sample_in(sample_in), .sample_valid(sample_valid),
    .sweep_up(sweep_up), .at_start(at_start), .request_lock(request_lock),
    .time_scale(time_scale), .n_instr(n_instr), .thr_flat(thr_flat),
    .wait_flat(wait_flat), .final_wait(final_wait),
    .instr_idx(instr_idx), .turn_on_lock(turn_on_lock)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int v);
    sample_in = 14'(v);
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic rewind();
    at_start = 1'b1;
    @(negedge clk);
    at_start = 1'b0;
  endtask

  task automatic set_instr(input int k, input int thr, input int wt);
    thr_flat[k*16 +: 16] = 16'(thr);
    wait_flat[k*12 +: 12] = 12'(wt);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12 reset idx", instr_idx, 0);
    chk("R12 reset lock", turn_on_lock, 0);

    // table walk: single instruction, R1 R2 R3 R5 R11
    for (int i = 0; i < 12; i++) begin
      n_instr = 3'd1;
      thr_flat = '0;
      wait_flat = '0;
      set_instr(0, ROWS[i].thr, ROWS[i].wt);
      final_wait = 12'd100;
      time_scale = ROWS[i].ts;
      request_lock = 1'b0;
      rewind();
      for (int s = 0; s < int'(ROWS[i].n); s++) push(ROWS[i].v);
      chk($sformatf("R1/R2/R3/R5/R11 table row %0d idx", i), instr_idx, int'(ROWS[i].exp_idx));
    end

    // four-instruction sequence, window of one sample
    time_scale = 5'd1;
    n_instr = 3'd4;
    set_instr(0, 500, 0);
    set_instr(1, -500, 3);
    set_instr(2, 800, 0);
    set_instr(3, -300, 2);
    final_wait = 12'd4;
    request_lock = 1'b0;
    rewind();
    push(600);
    chk("R4 first match", instr_idx, 1);
    repeat (3) push(-600);
    chk("R5 wait not elapsed", instr_idx, 1);
    push(-600);
    chk("R5 wait elapsed", instr_idx, 2);
    push(900);
    chk("R4 third match", instr_idx, 3);
    repeat (2) push(-400);
    chk("R5 counter restarted", instr_idx, 3);
    push(-400);
    chk("R4 last match", instr_idx, 4);
    repeat (5) push(0);
    chk("R8 no request no lock", turn_on_lock, 0);
    request_lock = 1'b1;
    push(0);
    chk("R8 lock with request", turn_on_lock, 1);
    request_lock = 1'b0;
    repeat (3) push(0);
    chk("R8 lock sticky", turn_on_lock, 1);
    rewind();
    chk("R9 rewind lock", turn_on_lock, 0);
    chk("R9 rewind idx", instr_idx, 0);

    // R7 final wait timing with no instructions (R6 count zero)
    n_instr = 3'd0;
    final_wait = 12'd2;
    request_lock = 1'b1;
    rewind();
    repeat (2) push(0);
    chk("R7 before final wait", turn_on_lock, 0);
    push(0);
    chk("R7 after final wait", turn_on_lock, 1);

    // R6 count above N_MAX acts as four
    n_instr = 3'd7;
    for (int k = 0; k < 4; k++) set_instr(k, 100, 0);
    final_wait = 12'd0;
    rewind();
    repeat (4) push(500);
    chk("R6 clamp idx", instr_idx, 4);
    push(500);
    chk("R6 clamp lock", turn_on_lock, 1);

    // R10 sample gating
    n_instr = 3'd1;
    request_lock = 1'b0;
    rewind();
    sweep_up = 1'b0;
    push(500);
    chk("R10 sweep down ignored", instr_idx, 0);
    sweep_up = 1'b1;
    sample_in = 14'sd500;
    repeat (3) @(negedge clk);
    chk("R10 invalid ignored", instr_idx, 0);
    push(500);
    chk("R10 accepted", instr_idx, 1);

    // R9 history cleared
    time_scale = 5'd5;
    set_instr(0, 30000, 0);
    rewind();
    repeat (3) push(1000);
    chk("R9 prefill no match", instr_idx, 0);
    set_instr(0, 150, 0);
    rewind();
    push(100);
    chk("R9 stale history gone", instr_idx, 0);
    push(100);
    chk("R1 sum of two", instr_idx, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule